// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder

This block sits between the 16-bit address bus of an 8-bit processor and the devices on that bus. It turns each address into one active-low chip enable. The upper half of the map belongs to the program ROM and the lowest quarter to RAM. The quarter between them is cut into four 4 KiB peripheral slots: a sound device, two interface adapters and a split I/O slot. The split slot is halved again, with its lower 2 KiB going to a serial interface and its upper 2 KiB to a general I/O window.

All decoding is combinational, and an address change reaches the enables without waiting for a clock edge. The RAM enable is the one exception: it is also qualified by the phase-2 bus clock, so RAM is never enabled while the address is still settling. A mode input switches on partial decoding. In that mode the window 0x8000–0xBFFF goes to a 16-register peripheral that sees only the four lowest address bits, so its registers repeat every 16 bytes, and ROM keeps only 0xC000–0xFFFF.

After reset every enable stays inactive until the block has seen the phase-2 input change level once. The slot assignment, the bus width and the availability of partial decoding are parameters.

Top module: `mem_map_decoder`

## Requirements
- R1: rom_cs_n is low for every address with bit 15 set, except that when mirror_mode is 1 it is low only for 0xC000–0xFFFF.
- R2: ram_cs_n is low for 0x0000–0x3FFF only while phi2 is 1. With phi2 at 0 it is high for every address.
- R3: snd_cs_n is low exactly for 0x7000–0x7FFF (bits 15..12 = 0111).
- R4: adp1_cs_n is low exactly for 0x6000–0x6FFF (bits 15..12 = 0110), and adp2_cs_n is low exactly for 0x5000–0x5FFF (bits 15..12 = 0101).
- R5: Inside 0x4000–0x4FFF, bit 11 picks the half. ser_cs_n is low for 0x4000–0x47FF (bit 11 = 0), and gio_cs_n is low for 0x4800–0x4FFF (bit 11 = 1).
- R6: With mirror_mode at 1, mir_cs_n is low for 0x8000–0xBFFF regardless of bits 13..4, so a 16-register device repeats every 16 bytes there. With mirror_mode at 0, mir_cs_n is never low.
- R7: At most one enable is low at any time. Once the block is armed and phi2 is 1, exactly one enable is low for every address.
- R8: From reset, all enables are high until phi2 has been sampled on a rising edge of clk at a level different from the previous sample. That sample is taken as 0 at reset. Arming takes effect at that edge and holds until the next reset.
- R9: Once the block is armed, an address change reaches the enables combinationally, with no clk edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples phi2 for arming |
| rst_n | input | 1 | Active-low asynchronous reset |
| phi2 | input | 1 | Phase-2 bus clock; qualifies the RAM enable |
| mirror_mode | input | 1 | 1 selects partial decoding of 0x8000–0xBFFF |
| addr | input | 16 | CPU address bus |
| rom_cs_n | output | 1 | ROM enable, active low |
| ram_cs_n | output | 1 | RAM enable, active low, only while phi2 is 1 |
| snd_cs_n | output | 1 | Sound device enable, active low |
| adp1_cs_n | output | 1 | Interface adapter 1 enable, active low |
| adp2_cs_n | output | 1 | Interface adapter 2 enable, active low |
| ser_cs_n | output | 1 | Serial interface enable (lower split half), active low |
| gio_cs_n | output | 1 | General I/O enable (upper split half), active low |
| mir_cs_n | output | 1 | Mirrored 16-register peripheral enable, active low |

## Verification
Two effects can land in the same cycle: the address decode, and the phase-2 qualification of RAM together with arming. The bench provokes this by flipping phi2 while the address sits inside RAM and at region edges, and by raising phi2 for the first time with a ROM address already on the bus. It judges each case by sampling 1 ns after every input change. It expects that no enable is low before the arming edge, that exactly one enable is low afterwards with phi2 at 1, and that none is low for a RAM address with phi2 at 0. A full sweep of all 65536 addresses in both decode modes, plus seeded random mixes of address, phi2 and mode, is checked against a reference map computed in the bench.

// File: rtl/adec_pkg.sv
package adec_pkg;

   // Index of each enable inside the internal select vector.
   typedef enum logic [2:0] {
      SEL_ROM  = 3'd0,
      SEL_RAM  = 3'd1,
      SEL_SND  = 3'd2,
      SEL_ADP1 = 3'd3,
      SEL_ADP2 = 3'd4,
      SEL_SER  = 3'd5,
      SEL_GIO  = 3'd6,
      SEL_MIR  = 3'd7
   } sel_e;

   localparam int unsigned NUM_SEL = 8;

   typedef logic [NUM_SEL-1:0] sel_vec_t;

   // Codes of the two top address bits.
   localparam logic [1:0] REG_RAM    = 2'b00;
   localparam logic [1:0] REG_PERIPH = 2'b01;
   localparam logic [1:0] REG_MIRROR = 2'b10;

endpackage

// File: rtl/adec_region.sv
module adec_region
   import adec_pkg::*;
#(
   parameter bit MIRROR_AVAIL = 1'b1
) (
   input  logic [1:0] a_hi,
   input  logic       mirror_mode,
   output logic       rom_hit,
   output logic       ram_hit,
   output logic       periph_hit,
   output logic       mir_hit
);

   assign ram_hit    = (a_hi == REG_RAM);
   assign periph_hit = (a_hi == REG_PERIPH);

   generate
      if (MIRROR_AVAIL) begin : g_mirror
         assign mir_hit = mirror_mode && (a_hi == REG_MIRROR);
         assign rom_hit = a_hi[1] && !mir_hit;
      end else begin : g_flat
         logic unused_mode;
         assign unused_mode = mirror_mode;
         assign mir_hit     = 1'b0;
         assign rom_hit     = a_hi[1];
      end
   endgenerate

endmodule

// File: rtl/adec_slot.sv
module adec_slot #(
   parameter int unsigned SLOT_BITS  = 2,
   parameter int unsigned SND_SLOT   = 3,
   parameter int unsigned ADP1_SLOT  = 2,
   parameter int unsigned ADP2_SLOT  = 1,
   parameter int unsigned SPLIT_SLOT = 0
) (
   input  logic                 periph_hit,
   input  logic [SLOT_BITS-1:0] slot_idx,
   input  logic                 half,
   output logic                 snd_hit,
   output logic                 adp1_hit,
   output logic                 adp2_hit,
   output logic                 ser_hit,
   output logic                 gio_hit
);

   localparam int unsigned NSLOT = 1 << SLOT_BITS;

   if (SND_SLOT >= NSLOT || ADP1_SLOT >= NSLOT ||
       ADP2_SLOT >= NSLOT || SPLIT_SLOT >= NSLOT) begin : g_bad_range
      $error("adec_slot: slot index outside the peripheral quarter");
   end
   if (SND_SLOT == ADP1_SLOT || SND_SLOT == ADP2_SLOT ||
       SND_SLOT == SPLIT_SLOT || ADP1_SLOT == ADP2_SLOT ||
       ADP1_SLOT == SPLIT_SLOT || ADP2_SLOT == SPLIT_SLOT) begin : g_bad_dup
      $error("adec_slot: two devices share one slot");
   end

   logic [NSLOT-1:0] slot_hit;

   generate
      for (genvar i = 0; i < NSLOT; i++) begin : g_slot
         assign slot_hit[i] = periph_hit && (slot_idx == SLOT_BITS'(i));
      end
   endgenerate

   assign snd_hit  = slot_hit[SND_SLOT];
   assign adp1_hit = slot_hit[ADP1_SLOT];
   assign adp2_hit = slot_hit[ADP2_SLOT];
   assign ser_hit  = slot_hit[SPLIT_SLOT] && !half;
   assign gio_hit  = slot_hit[SPLIT_SLOT] &&  half;

endmodule

// File: rtl/adec_gate.sv
module adec_gate
   import adec_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     phi2,
   input  sel_vec_t hits,
   output sel_vec_t sel_n,
   output logic     armed
);

   logic     phi2_q;
   sel_vec_t qual;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phi2_q <= 1'b0;
         armed  <= 1'b0;
      end else begin
         phi2_q <= phi2;
         armed  <= armed | (phi2 ^ phi2_q);
      end
   end

   always_comb begin
      qual          = hits;
      qual[SEL_RAM] = hits[SEL_RAM] & phi2;
      sel_n         = armed ? ~qual : '1;
   end

   // R8: arming is sticky until reset
   a_r8_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      armed |=> armed);

   // R2: RAM enable never active while phi2 is low
   a_r2_ram_phase: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_n[SEL_RAM] |-> phi2);

endmodule

// File: rtl/mem_map_decoder.sv
module mem_map_decoder
   import adec_pkg::*;
#(
   parameter int unsigned ADDR_W       = 16,
   parameter int unsigned SLOT_BITS    = 2,
   parameter int unsigned SND_SLOT     = 3,
   parameter int unsigned ADP1_SLOT    = 2,
   parameter int unsigned ADP2_SLOT    = 1,
   parameter int unsigned SPLIT_SLOT   = 0,
   parameter bit          MIRROR_AVAIL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2,
   input  logic              mirror_mode,
   input  logic [ADDR_W-1:0] addr,
   output logic              rom_cs_n,
   output logic              ram_cs_n,
   output logic              snd_cs_n,
   output logic              adp1_cs_n,
   output logic              adp2_cs_n,
   output logic              ser_cs_n,
   output logic              gio_cs_n,
   output logic              mir_cs_n
);

   localparam int unsigned SLOT_TOP = ADDR_W - 3;
   localparam int unsigned HALF_BIT = SLOT_TOP - SLOT_BITS;
   localparam int unsigned LOW_TOP  = HALF_BIT - 1;

   if (ADDR_W < SLOT_BITS + 4) begin : g_bad_width
      $error("mem_map_decoder: address bus too narrow for the slot layout");
   end

   logic [1:0]           a_hi;
   logic [SLOT_BITS-1:0] slot_idx;
   logic                 half;
   logic [LOW_TOP:0]     unused_low;

   assign a_hi       = addr[ADDR_W-1 -: 2];
   assign slot_idx   = addr[SLOT_TOP -: SLOT_BITS];
   assign half       = addr[HALF_BIT];
   assign unused_low = addr[LOW_TOP:0];

   logic     rom_hit, ram_hit, periph_hit, mir_hit;
   logic     snd_hit, adp1_hit, adp2_hit, ser_hit, gio_hit;
   sel_vec_t hits, sel_n;
   logic     armed;

   adec_region #(.MIRROR_AVAIL(MIRROR_AVAIL)) u_region (
      .a_hi        (a_hi),
      .mirror_mode (mirror_mode),
      .rom_hit     (rom_hit),
      .ram_hit     (ram_hit),
      .periph_hit  (periph_hit),
      .mir_hit     (mir_hit)
   );

   adec_slot #(
      .SLOT_BITS  (SLOT_BITS),
      .SND_SLOT   (SND_SLOT),
      .ADP1_SLOT  (ADP1_SLOT),
      .ADP2_SLOT  (ADP2_SLOT),
      .SPLIT_SLOT (SPLIT_SLOT)
   ) u_slot (
      .periph_hit (periph_hit),
      .slot_idx   (slot_idx),
      .half       (half),
      .snd_hit    (snd_hit),
      .adp1_hit   (adp1_hit),
      .adp2_hit   (adp2_hit),
      .ser_hit    (ser_hit),
      .gio_hit    (gio_hit)
   );

   always_comb begin
      hits           = '0;
      hits[SEL_ROM]  = rom_hit;
      hits[SEL_RAM]  = ram_hit;
      hits[SEL_SND]  = snd_hit;
      hits[SEL_ADP1] = adp1_hit;
      hits[SEL_ADP2] = adp2_hit;
      hits[SEL_SER]  = ser_hit;
      hits[SEL_GIO]  = gio_hit;
      hits[SEL_MIR]  = mir_hit;
   end

   adec_gate u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .phi2  (phi2),
      .hits  (hits),
      .sel_n (sel_n),
      .armed (armed)
   );

   assign rom_cs_n  = sel_n[SEL_ROM];
   assign ram_cs_n  = sel_n[SEL_RAM];
   assign snd_cs_n  = sel_n[SEL_SND];
   assign adp1_cs_n = sel_n[SEL_ADP1];
   assign adp2_cs_n = sel_n[SEL_ADP2];
   assign ser_cs_n  = sel_n[SEL_SER];
   assign gio_cs_n  = sel_n[SEL_GIO];
   assign mir_cs_n  = sel_n[SEL_MIR];

   logic [NUM_SEL-1:0] act;
   assign act = ~{mir_cs_n, gio_cs_n, ser_cs_n, adp2_cs_n,
                  adp1_cs_n, snd_cs_n, ram_cs_n, rom_cs_n};

   // R7: never two enables at once
   a_r7_at_most_one: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act));

   // R7: exactly one once armed with phi2 high
   a_r7_exactly_one: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && phi2) |-> ($countones(act) == 1));

   // R1: ROM only in the upper half
   a_r1_rom_upper: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_cs_n |-> a_hi[1]);

   // R5: serial half only in the lower split half
   a_r5_ser_window: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_cs_n |-> (a_hi == REG_PERIPH && slot_idx == SLOT_BITS'(SPLIT_SLOT) && !half));

   // R6: mirror enable only in mirror mode and its window
   a_r6_mirror_window: assert property (@(posedge clk) disable iff (!rst_n)
      !mir_cs_n |-> (mirror_mode && a_hi == REG_MIRROR));

endmodule

// File: tb/mem_map_decoder_bench.sv
module mem_map_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        phi2 = 1'b0;
   logic        mirror_mode = 1'b0;
   logic [15:0] addr = 16'hC000;
   logic rom_cs_n, ram_cs_n, snd_cs_n, adp1_cs_n, adp2_cs_n, ser_cs_n, gio_cs_n, mir_cs_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mem_map_decoder u_mem_map_decoder (
      .clk(clk), .rst_n(rst_n), .phi2(phi2), .mirror_mode(mirror_mode), .addr(addr),
      .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n), .snd_cs_n(snd_cs_n),
      .adp1_cs_n(adp1_cs_n), .adp2_cs_n(adp2_cs_n), .ser_cs_n(ser_cs_n),
      .gio_cs_n(gio_cs_n), .mir_cs_n(mir_cs_n)
   );

   // Bit order: [7]mir [6]gio [5]ser [4]adp2 [3]adp1 [2]snd [1]ram [0]rom, active high
   function automatic logic [7:0] observed();
      return ~{mir_cs_n, gio_cs_n, ser_cs_n, adp2_cs_n, adp1_cs_n, snd_cs_n, ram_cs_n, rom_cs_n};
   endfunction

   function automatic logic [7:0] ref_map(logic [15:0] a, logic p, logic m);
      logic [7:0] v = 8'h00;
      if (a[15]) begin
         if (m && !a[14]) v[7] = 1'b1;
         else             v[0] = 1'b1;
      end else if (!a[14]) begin
         v[1] = p;
      end else begin
         case (a[13:12])
            2'b11:   v[2] = 1'b1;
            2'b10:   v[3] = 1'b1;
            2'b01:   v[4] = 1'b1;
            default: if (a[11]) v[6] = 1'b1; else v[5] = 1'b1;
         endcase
      end
      return v;
   endfunction

   function automatic string req_of(logic [15:0] a, logic m);
      if (a[15])  return (m && !a[14]) ? "R6" : "R1";
      if (!a[14]) return "R2";
      case (a[13:12])
         2'b11:   return "R3";
         2'b00:   return "R5";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s addr=%h phi2=%0b mode=%0b got=%b exp=%b",
                  req, addr, phi2, mirror_mode, got, exp);
      end
   endtask

   task automatic apply(logic [15:0] a, logic p, logic m, string req);
      addr = a; phi2 = p; mirror_mode = m;
      #1;
      chk(req, observed(), ref_map(a, p, m));
   endtask

   initial begin
      #4_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R8: reset state, all enables high
      #5;
      chk("R8", observed(), 8'h00);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      chk("R8", observed(), 8'h00);           // phi2 never changed
      @(negedge clk); phi2 = 1'b1; #1;
      chk("R8", observed(), 8'h00);           // change seen, no edge yet
      @(posedge clk); #1;
      chk("R8", observed(), 8'h01);           // armed: ROM at 0xC000
      @(negedge clk); phi2 = 1'b0; #1;
      chk("R8", observed(), 8'h01);           // stays armed

      // R2: phase qualification of RAM
      apply(16'h1234, 1'b1, 1'b0, "R2");
      chk("R2", observed(), 8'h02);
      apply(16'h1234, 1'b0, 1'b0, "R2");
      chk("R2", observed(), 8'h00);
      apply(16'h3FFF, 1'b1, 1'b0, "R2");

      // R9: address change reaches outputs with no edge
      @(negedge clk);
      addr = 16'h7ABC; #2;
      chk("R9", observed(), 8'h04);
      addr = 16'h6001; #2;
      chk("R9", observed(), 8'h08);

      // Directed region boundaries
      apply(16'h4000, 1'b1, 1'b0, "R5");
      apply(16'h47FF, 1'b1, 1'b0, "R5");
      apply(16'h4800, 1'b1, 1'b0, "R5");
      apply(16'h4FFF, 1'b1, 1'b0, "R5");
      apply(16'h5000, 1'b1, 1'b0, "R4");
      apply(16'h5FFF, 1'b1, 1'b0, "R4");
      apply(16'h6FFF, 1'b1, 1'b0, "R4");
      apply(16'h7000, 1'b1, 1'b0, "R3");
      apply(16'h7FFF, 1'b1, 1'b0, "R3");
      apply(16'h8000, 1'b1, 1'b0, "R1");
      apply(16'hFFFF, 1'b1, 1'b0, "R1");
      apply(16'h8000, 1'b1, 1'b1, "R6");
      apply(16'hBFFF, 1'b1, 1'b1, "R6");
      apply(16'hC000, 1'b1, 1'b1, "R1");
      apply(16'hA5F3, 1'b1, 1'b0, "R6");       // mode off: no mirror

      // R7: full sweep in both modes with phi2 high
      for (int m = 0; m < 2; m++) begin
         for (int a = 0; a < 65536; a++) begin
            addr = a[15:0]; phi2 = 1'b1; mirror_mode = m[0];
            #1;
            chk(req_of(addr, mirror_mode), observed(), ref_map(addr, 1'b1, m[0]));
            checks++;
            if ($countones(observed()) != 1) begin
               errors++;
               $display("FAIL R7 addr=%h got=%b exp=one-hot", addr, observed());
            end
         end
      end

      // Seeded random mix including phi2 low
      void'($urandom(32'd1357));
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] ra;
         logic        rp, rm;
         ra = 16'($urandom());
         rp = 1'($urandom());
         rm = 1'($urandom());
         apply(ra, rp, rm, req_of(ra, rm));
         checks++;
         if ($countones(observed()) > 1) begin
            errors++;
            $display("FAIL R7 addr=%h got=%b exp=at-most-one", addr, observed());
         end
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule